// File: doc/BRIEF.md
# Serial Converter Readout Controller

This block is the host side of a three-wire link to a continuously converting ADC. The converter has no separate ready pin. It signals that a result is waiting by pulling its serial data line low. The controller passes that line through a synchroniser and watches for the low level. It then issues a burst of exactly 32 serial clock pulses while holding its own serial output line low. During the burst it shifts in an 8-bit status prefix followed by a 24-bit conversion result.

When the burst ends, the controller checks the five leading status bits against the fixed header. A good word is presented on a parallel port: the channel indicator, two condition flags and the 24-bit result, together with a one-clock valid strobe. A word whose header is wrong raises a framing-error strobe instead, and the parallel port keeps its last good contents. The serial clock rate is set by a divider of the system clock. Before a new readout can start, the data line must be seen back at its idle high level.

Top module: `adc_rdout_ctrl`

## Requirements
- R1: `sclk` rests low and no serial clock pulse is produced until the synchronised data line (two flip-flops) is seen low; that low level starts a readout.
- R2: Every readout produces exactly 32 rising edges on `sclk`, and no more.
- R3: `sdi` is driven low at all times, including throughout every readout.
- R4: Each high phase of `sclk` lasts `clk_div`+1 system clocks. The value of `clk_div` is captured when a readout starts, so a change during a readout has no effect on it. Supported values are `clk_div` >= 2.
- R5: One bit is captured on each rising edge of `sclk`, and the first bit captured becomes word bit 31. Bits 31:27 are the header, bit 26 is the channel, bit 25 is the oscillation flag, bit 24 is the overflow flag, and bits 23:0 are the result, most significant bit first.
- R6: When the header bits 31:27 equal 01111, `rd_valid` is high for exactly one clock, one cycle after the last falling edge of `sclk`. In that cycle `rd_chan`, `rd_osc`, `rd_ovf` and `rd_data` carry the word's fields, and they hold those values afterwards.
- R7: When the header differs from 01111, `frame_err` is high for one clock and `rd_valid` stays low. `rd_chan`, `rd_osc`, `rd_ovf` and `rd_data` keep their previous values.
- R8: After a readout completes, no new readout starts until the data line has been seen high. A line held low after a readout produces no further `sclk` pulses.
- R9: After reset, `sclk`, `rd_valid`, `frame_err`, `rd_chan`, `rd_osc`, `rd_ovf` and `rd_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_div | input | DIV_W | Serial clock half-period minus one, in system clocks |
| sdo | input | 1 | Serial data from the converter; a low level means a result is ready |
| sclk | output | 1 | Serial clock to the converter, idle low |
| sdi | output | 1 | Serial data to the converter, always low |
| rd_valid | output | 1 | One-clock strobe for a good word |
| frame_err | output | 1 | One-clock strobe for a word with a bad header |
| rd_chan | output | 1 | Channel indicator of the last good word |
| rd_osc | output | 1 | Oscillation flag of the last good word |
| rd_ovf | output | 1 | Overflow flag of the last good word |
| rd_data | output | 24 | Conversion result of the last good word |

## Verification
Two events can land in the same cycle. The final falling edge of `sclk` publishes the word, and in that same cycle the converter releases its data line and the controller enters its wait-for-high state. The bench provokes this by raising the line right after that last falling edge, then lowering it again a few cycles later for a back-to-back readout. It judges the result by requiring, for each readout, exactly one strobe carrying the right fields and exactly 32 pulses. In a further case the line is held low after a readout, and the bench requires that no extra pulse appears.

// File: rtl/adc_rdout_pkg.sv
package adc_rdout_pkg;

  localparam int STAT_W = 8;
  localparam int DATA_W = 24;
  localparam int WORD_W = STAT_W + DATA_W;
  localparam int HDR_W  = 5;
  localparam int CNT_W  = $clog2(WORD_W + 1);
  localparam logic [HDR_W-1:0] HDR_PATTERN = 5'b01111;

  // Bit positions of the fields inside the received word
  localparam int POS_CHAN = DATA_W + 2;
  localparam int POS_OSC  = DATA_W + 1;
  localparam int POS_OVF  = DATA_W;

  typedef enum logic [1:0] {
    RS_ARMED = 2'd0,
    RS_SHIFT = 2'd1,
    RS_REARM = 2'd2
  } rd_state_t;

  typedef struct packed {
    logic              chan;
    logic              osc;
    logic              ovf;
    logic [DATA_W-1:0] data;
  } rd_result_t;

  function automatic logic header_ok(input logic [WORD_W-1:0] w);
    return w[WORD_W-1 -: HDR_W] == HDR_PATTERN;
  endfunction

  function automatic rd_result_t split_word(input logic [WORD_W-1:0] w);
    rd_result_t r;
    r.chan = w[POS_CHAN];
    r.osc  = w[POS_OSC];
    r.ovf  = w[POS_OVF];
    r.data = w[DATA_W-1:0];
    return r;
  endfunction

endpackage

// File: rtl/adc_rdout_sync.sv
module adc_rdout_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= RST_VAL;
        else        chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/adc_rdout_sclk.sv
module adc_rdout_sclk #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             sclk,
  output logic             rise_evt,
  output logic             fall_evt
);

  logic [DIV_W-1:0] cnt;
  logic             edge_now;

  assign edge_now = run && (cnt == div);
  assign rise_evt = edge_now && !sclk;
  assign fall_evt = edge_now && sclk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (!run) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (edge_now) begin
      cnt  <= '0;
      sclk <= ~sclk;
    end else begin
      cnt  <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/adc_rdout_shift.sv
module adc_rdout_shift
  import adc_rdout_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              capture,
  input  logic              din,
  output logic [WORD_W-1:0] word,
  output logic [CNT_W-1:0]  bit_cnt
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word    <= '0;
      bit_cnt <= '0;
    end else if (start) begin
      word    <= '0;
      bit_cnt <= '0;
    end else if (capture) begin
      word    <= {word[WORD_W-2:0], din};
      bit_cnt <= bit_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/adc_rdout_publish.sv
module adc_rdout_publish
  import adc_rdout_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_done,
  input  logic [WORD_W-1:0] word,
  output logic              rd_valid,
  output logic              frame_err,
  output rd_result_t        result
);

  logic hdr_good;

  assign hdr_good = header_ok(word);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid  <= 1'b0;
      frame_err <= 1'b0;
      result    <= '0;
    end else begin
      rd_valid  <= frame_done && hdr_good;
      frame_err <= frame_done && !hdr_good;
      if (frame_done && hdr_good) result <= split_word(word);
    end
  end

endmodule

// File: rtl/adc_rdout_ctrl.sv
module adc_rdout_ctrl
  import adc_rdout_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  clk_div,
  input  logic              sdo,
  output logic              sclk,
  output logic              sdi,
  output logic              rd_valid,
  output logic              frame_err,
  output logic              rd_chan,
  output logic              rd_osc,
  output logic              rd_ovf,
  output logic [DATA_W-1:0] rd_data
);

  rd_state_t         state, state_nx;
  logic              sdo_s;
  logic              start_evt;
  logic              frame_done;
  logic              rise_evt;
  logic              fall_evt;
  logic              run;
  logic [DIV_W-1:0]  div_q;
  logic [CNT_W-1:0]  bit_cnt;
  logic [WORD_W-1:0] word;
  rd_result_t        result;

  adc_rdout_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(sdo), .q(sdo_s)
  );

  always_comb begin
    state_nx   = state;
    start_evt  = 1'b0;
    frame_done = 1'b0;
    case (state)
      RS_ARMED: if (!sdo_s) begin
        start_evt = 1'b1;
        state_nx  = RS_SHIFT;
      end
      RS_SHIFT: if (fall_evt && bit_cnt == CNT_W'(WORD_W)) begin
        frame_done = 1'b1;
        state_nx   = RS_REARM;
      end
      RS_REARM: if (sdo_s) state_nx = RS_ARMED;
      default:  state_nx = RS_REARM;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= RS_ARMED;
      div_q <= '0;
    end else begin
      state <= state_nx;
      if (start_evt) div_q <= clk_div;
    end
  end

  assign run = (state == RS_SHIFT);

  adc_rdout_sclk #(.DIV_W(DIV_W)) u_sclk (
    .clk(clk), .rst_n(rst_n), .run(run), .div(div_q),
    .sclk(sclk), .rise_evt(rise_evt), .fall_evt(fall_evt)
  );

  adc_rdout_shift u_shift (
    .clk(clk), .rst_n(rst_n), .start(start_evt), .capture(rise_evt),
    .din(sdo_s), .word(word), .bit_cnt(bit_cnt)
  );

  adc_rdout_publish u_pub (
    .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .word(word),
    .rd_valid(rd_valid), .frame_err(frame_err), .result(result)
  );

  assign sdi     = 1'b0;
  assign rd_chan = result.chan;
  assign rd_osc  = result.osc;
  assign rd_ovf  = result.ovf;
  assign rd_data = result.data;

endmodule

// File: rtl/adc_rdout_ctrl_chk.sv
module adc_rdout_ctrl_chk
  import adc_rdout_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              sclk,
  input logic              sdi,
  input logic              sdo_s,
  input logic              rd_valid,
  input logic              frame_err,
  input logic [DATA_W-1:0] rd_data,
  input rd_state_t         state,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic              frame_done,
  input logic              rise_evt
);

  a_r1_idle_sclk_low: assert property (@(posedge clk) disable iff (!rst_n)
    (state != RS_SHIFT) |-> !sclk);

  a_r2_done_after_all_bits: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (bit_cnt == CNT_W'(WORD_W)));

  a_r2_no_extra_rise: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt |-> (bit_cnt < CNT_W'(WORD_W)));

  a_r3_sdi_low: assert property (@(posedge clk) disable iff (!rst_n)
    !sdi);

  a_r6_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  a_r6_publish_follows_done: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> (rd_valid || frame_err));

  a_r7_err_excludes_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && frame_err));

  a_r7_err_holds_data: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> $stable(rd_data));

  a_r8_wait_for_high: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RS_REARM && !sdo_s) |=> (state != RS_SHIFT));

endmodule

bind adc_rdout_ctrl adc_rdout_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdi(sdi), .sdo_s(sdo_s),
  .rd_valid(rd_valid), .frame_err(frame_err), .rd_data(rd_data),
  .state(state), .bit_cnt(bit_cnt), .frame_done(frame_done),
  .rise_evt(rise_evt)
);

// File: tb/adc_rdout_ctrl_test.sv
module adc_rdout_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  clk_div;
  logic        sdo;
  logic        sclk, sdi, rd_valid, frame_err, rd_chan, rd_osc, rd_ovf;
  logic [23:0] rd_data;

  always #4 clk = ~clk;

  adc_rdout_ctrl uut (
    .clk(clk), .rst_n(rst_n), .clk_div(clk_div), .sdo(sdo),
    .sclk(sclk), .sdi(sdi), .rd_valid(rd_valid), .frame_err(frame_err),
    .rd_chan(rd_chan), .rd_osc(rd_osc), .rd_ovf(rd_ovf), .rd_data(rd_data)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  typedef struct {
    bit          bad;
    bit          ch;
    bit          osc;
    bit          ovf;
    logic [23:0] data;
  } exp_t;

  exp_t q[$];

  int          rises = 0;
  int          cur_div = 0;
  int          hi_run = 0;
  bit          width_bad = 0;
  bit          sdi_bad = 0;
  bit          pub_prev = 0;
  bit          double_pub = 0;
  logic [23:0] last_data = '0;
  bit          last_ch = 0, last_osc = 0, last_ovf = 0;

  always @(posedge sclk) rises++;

  // R4: high phase width and R3 sdi level, sampled away from the clock edge
  always @(negedge clk) begin
    if (sdi !== 1'b0) sdi_bad = 1;
    if (sclk) hi_run++;
    else begin
      if (hi_run != 0 && hi_run != cur_div + 1) width_bad = 1;
      hi_run = 0;
    end
  end

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (pub_prev && (rd_valid || frame_err)) double_pub = 1;
      pub_prev = rd_valid || frame_err;
      if (rd_valid || frame_err) begin
        if (q.size() == 0) begin
          chk(0, "R6", "unexpected strobe", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(frame_err == e.bad, "R7", "frame_err", int'(frame_err), int'(e.bad));
          chk(rd_valid == !e.bad, "R6", "rd_valid", int'(rd_valid), int'(!e.bad));
          chk(rises == 32, "R2", "sclk rising edges", rises, 32);
          chk(!width_bad, "R4", "sclk high width", hi_run, cur_div + 1);
          width_bad = 0;
          if (!e.bad) begin
            chk(rd_data == e.data, "R5", "rd_data", int'(rd_data), int'(e.data));
            chk({rd_chan, rd_osc, rd_ovf} == {e.ch, e.osc, e.ovf}, "R6", "chan/flags",
                int'({rd_chan, rd_osc, rd_ovf}), int'({e.ch, e.osc, e.ovf}));
            last_data = e.data; last_ch = e.ch; last_osc = e.osc; last_ovf = e.ovf;
          end else begin
            chk(rd_data == last_data, "R7", "rd_data held", int'(rd_data), int'(last_data));
            chk({rd_chan, rd_osc, rd_ovf} == {last_ch, last_osc, last_ovf}, "R7",
                "chan/flags held", int'({rd_chan, rd_osc, rd_ovf}),
                int'({last_ch, last_osc, last_ovf}));
          end
        end
      end
    end
  end

  // Driver: converter model shifting on falling sclk edges
  task automatic send(input logic [7:0] st, input logic [23:0] d, input int div,
                      input bit hold_low, input int mid_div, input int gap);
    logic [31:0] w;
    exp_t e;
    w      = {st, d};
    e.bad  = (st[7:3] != 5'b01111);
    e.ch   = st[2];
    e.osc  = st[1];
    e.ovf  = st[0];
    e.data = d;
    q.push_back(e);
    @(negedge clk);
    clk_div = 8'(div);
    cur_div = div;
    rises   = 0;
    sdo     = w[31];
    for (int k = 1; k < 32; k++) begin
      @(negedge sclk);
      #1;
      sdo = w[31-k];
      if (k == 6 && mid_div >= 0) clk_div = 8'(mid_div);
    end
    @(negedge sclk);
    #1;
    if (hold_low) begin
      sdo = 1'b0;
      repeat (300) @(negedge clk);
      chk(rises == 32, "R8", "pulses while line held low", rises, 32);
    end
    sdo = 1'b1;
    repeat (gap) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "R2", "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n   = 1'b0;
    sdo     = 1'b1;
    clk_div = 8'd2;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sclk == 0 && rd_valid == 0 && frame_err == 0, "R9", "reset strobes/sclk",
        int'({sclk, rd_valid, frame_err}), 0);
    chk(rd_data == 0 && {rd_chan, rd_osc, rd_ovf} == 0, "R9", "reset fields",
        int'(rd_data), 0);
    repeat (50) @(negedge clk);
    chk(rises == 0, "R1", "sclk idle while line high", rises, 0);

    send({5'b01111, 3'b000}, 24'h123456, 2, 0, -1, 6);
    send({5'b01111, 3'b110}, 24'hFFFFFF, 3, 0, -1, 6);
    // R4: divider changed mid readout must not alter the phase width
    send({5'b01111, 3'b001}, 24'h000001, 5, 0, 2, 6);
    // R7: header bit wrong in two different positions
    send({5'b01101, 3'b111}, 24'hABCDEF, 2, 0, -1, 6);
    send({5'b00111, 3'b010}, 24'h55AA55, 4, 0, -1, 6);
    // R8: line held low after the readout
    send({5'b01111, 3'b111}, 24'h800000, 2, 1, -1, 6);
    // back-to-back readouts with a short high gap
    send({5'b01111, 3'b100}, 24'h5A5A5A, 4, 0, -1, 3);
    send({5'b01111, 3'b011}, 24'h000000, 2, 0, -1, 3);
    send({5'b01111, 3'b101}, 24'hC3C3C3, 3, 0, -1, 20);

    chk(q.size() == 0, "R6", "results outstanding", q.size(), 0);
    chk(!double_pub, "R6", "strobe longer than one clock", int'(double_pub), 0);
    chk(!sdi_bad, "R3", "sdi level", int'(sdi_bad), 0);
    chk(sclk == 0, "R1", "sclk idle after traffic", int'(sclk), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule